// File: doc/BRIEF.md
# PLL Power-Up Sequencer

This block brings a phase-locked loop out of its powered-down state in a fixed order and takes it back down in the reverse order. It runs on the reference clock. When the enable input is seen high while idle, it first lets go of the PLL's active-low reset. After a guard time of ten microseconds it takes the PLL out of bypass. After a further lock wait of sixty microseconds it switches the PLL output on and raises a ready flag. The hardware only needs five microseconds between reset release and bypass exit, so the ten-microsecond guard leaves a margin.

A low enable level is a shutdown request. The sequencer then clears the output enable, the bypass-disable and the reset release, one per cycle, so the PLL always returns to a safe state in the reverse of its start-up order. Both waits are counted in reference cycles. The counts are derived at elaboration from a parameter that gives the reference frequency. An optional lock input can hold back the final step until the PLL reports that it has locked.

Top module: `pll_startup_seq`

## Requirements
- R1: While reset is asserted, and afterwards while the block is idle, all four outputs are low: PLL reset held (pll_rst_n_o = 0), bypass active, output off and not ready.
- R2: The first clock edge that samples en_i high while idle raises pll_rst_n_o. bypass_off_o and out_en_o stay low.
- R3: bypass_off_o rises exactly T_REL cycles after pll_rst_n_o rises. T_REL = ceil(REF_HZ × RELEASE_US / 10^6), with a minimum of 1; this is 270 cycles at 27 MHz and 10 µs, and 10 cycles at 1 MHz.
- R4: With lock_i high, out_en_o rises exactly T_LOCK cycles after bypass_off_o rises. T_LOCK is derived from LOCK_US (60 µs by default) in the same way as T_REL.
- R5: With WAIT_LOCK = 1, out_en_o stays low while lock_i is low, even after T_LOCK has elapsed. It rises on the first edge that samples lock_i high once the wait is over.
- R6: ready_o is high exactly when out_en_o is high.
- R7: A low en_i seen while running clears out_en_o on that edge, bypass_off_o on the next edge and pll_rst_n_o on the edge after that.
- R8: A low en_i seen during the lock wait clears bypass_off_o on that edge and pll_rst_n_o on the next. A low en_i seen during the reset-release guard time clears pll_rst_n_o on that edge.
- R9: Once a shutdown has begun, a high en_i does not restart the sequence. The shutdown runs to idle, and only the edge after that starts a new bring-up.
- R10: While running, lock_i going low has no effect on the outputs.
- R11: out_en_o is never high unless bypass_off_o and pll_rst_n_o are high, and bypass_off_o is never high unless pll_rst_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| en_i | input | 1 | Level request: high to run the PLL, low to shut it down |
| lock_i | input | 1 | Lock indication from the PLL, used when WAIT_LOCK = 1 |
| pll_rst_n_o | output | 1 | Active-low PLL reset; high means released |
| bypass_off_o | output | 1 | High takes the PLL out of bypass |
| out_en_o | output | 1 | High enables the PLL output |
| ready_o | output | 1 | PLL output is enabled and usable |

## Verification
The hardest cases to reach from the ports are a shutdown that arrives at a particular cycle of the bring-up, and an enable that comes back partway through a shutdown. Each shutdown branch depends on the exact phase reached when en_i falls.

The bench uses a 1 MHz reference, which gives waits of 10 and 60 cycles. It sweeps the point at which en_i drops across every cycle from the first edge to past the end of the sequence. At each cycle it compares the expected output pattern, computed from the elapsed cycle count, with the outputs. Separate runs hold lock_i low past the lock wait, drop lock_i while running, and raise en_i again in the first shutdown cycle.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_RELEASE  = 3'd1,
    S_LOCKWAIT = 3'd2,
    S_RUN      = 3'd3,
    S_DROP_OE  = 3'd4,
    S_DROP_BYP = 3'd5
  } seq_state_e;

  // Cycles covering a wait of 'us' microseconds at 'hz', rounded up, at least 1.
  function automatic int unsigned us_to_cycles(longint unsigned hz, int unsigned us);
    longint unsigned prod;
    longint unsigned cyc;
    prod = hz * 64'(us);
    cyc  = (prod + 64'd999_999) / 64'd1_000_000;
    if (cyc == 64'd0) cyc = 64'd1;
    return cyc[31:0];
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = (cnt == (limit - CW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (!done)  cnt <= cnt + CW'(1);
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt < limit);

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter bit WAIT_LOCK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       lock_i,
  input  logic       tmr_done_i,
  output seq_state_e state_o,
  output logic       tmr_clr_o,
  output logic       pll_rst_n_o,
  output logic       bypass_off_o,
  output logic       out_en_o,
  output logic       ready_o
);
  seq_state_e state_q, state_d;

  // Named step events
  logic lock_ok, ev_release, ev_bypass, ev_output, ev_shutdown;
  assign lock_ok     = lock_i | ~WAIT_LOCK;
  assign ev_release  = (state_q == S_IDLE) && en_i;
  assign ev_bypass   = (state_q == S_RELEASE) && en_i && tmr_done_i;
  assign ev_output   = (state_q == S_LOCKWAIT) && en_i && tmr_done_i && lock_ok;
  assign ev_shutdown = !en_i && ((state_q == S_RELEASE) || (state_q == S_LOCKWAIT) ||
                                 (state_q == S_RUN));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (ev_release) state_d = S_RELEASE;
      S_RELEASE:  if (!en_i) state_d = S_IDLE;
                  else if (ev_bypass) state_d = S_LOCKWAIT;
      S_LOCKWAIT: if (!en_i) state_d = S_DROP_BYP;
                  else if (ev_output) state_d = S_RUN;
      S_RUN:      if (!en_i) state_d = S_DROP_OE;
      S_DROP_OE:  state_d = S_DROP_BYP;
      S_DROP_BYP: state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign tmr_clr_o = (state_d != state_q);

  assign pll_rst_n_o  = (state_q != S_IDLE);
  assign bypass_off_o = (state_q == S_LOCKWAIT) || (state_q == S_RUN) || (state_q == S_DROP_OE);
  assign out_en_o     = (state_q == S_RUN);
  assign ready_o      = out_en_o;

  // R11
  oe_needs_bypass_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_o |-> (bypass_off_o && pll_rst_n_o));
  // R11
  bypass_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_off_o |-> pll_rst_n_o);
  // R6
  ready_only_with_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> out_en_o);
  // R2
  release_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rst_n_o) |-> (!bypass_off_o && !out_en_o));
  // R3
  bypass_after_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_off_o) |-> $past(tmr_done_i));
  // R4
  output_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en_o) |-> ($past(tmr_done_i) && $past(lock_ok)));
  // R7
  bypass_drop_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_off_o) |-> (!out_en_o && $past(!out_en_o)));
  // R8
  reset_drop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst_n_o) |-> $past(!bypass_off_o));
  // R9
  no_restart_in_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DROP_OE) |=> (state_q == S_DROP_BYP));

endmodule

// File: rtl/pll_startup_seq.sv
module pll_startup_seq
  import pll_seq_pkg::*;
#(
  parameter longint unsigned REF_HZ     = 64'd27_000_000,
  parameter int unsigned     RELEASE_US = 10,
  parameter int unsigned     LOCK_US    = 60,
  parameter bit              WAIT_LOCK  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic lock_i,
  output logic pll_rst_n_o,
  output logic bypass_off_o,
  output logic out_en_o,
  output logic ready_o
);
  localparam int unsigned T_REL  = us_to_cycles(REF_HZ, RELEASE_US);
  localparam int unsigned T_LOCK = us_to_cycles(REF_HZ, LOCK_US);
  localparam int unsigned T_MAX  = max_u(T_REL, T_LOCK);
  localparam int unsigned CW     = (T_MAX < 2) ? 1 : $clog2(T_MAX + 1);
  localparam logic [CW-1:0] LIM_REL  = CW'(T_REL);
  localparam logic [CW-1:0] LIM_LOCK = CW'(T_LOCK);

  seq_state_e    state;
  logic          tmr_clr, tmr_done;
  logic [CW-1:0] tmr_limit;

  assign tmr_limit = (state == S_LOCKWAIT) ? LIM_LOCK : LIM_REL;

  pll_seq_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  pll_seq_fsm #(.WAIT_LOCK(WAIT_LOCK)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .lock_i       (lock_i),
    .tmr_done_i   (tmr_done),
    .state_o      (state),
    .tmr_clr_o    (tmr_clr),
    .pll_rst_n_o  (pll_rst_n_o),
    .bypass_off_o (bypass_off_o),
    .out_en_o     (out_en_o),
    .ready_o      (ready_o)
  );

endmodule

// File: tb/tb_pll_startup_seq.sv
`timescale 1ns/1ps
module tb_pll_startup_seq;
  // 1 MHz reference: 10 us -> 10 cycles, 60 us -> 60 cycles
  localparam int T1 = 1 * 10;
  localparam int T2 = 1 * 60;

  localparam logic [3:0] P_IDLE = 4'b0000;
  localparam logic [3:0] P_REL  = 4'b1000;
  localparam logic [3:0] P_LW   = 4'b1100;
  localparam logic [3:0] P_RUN  = 4'b1111;
  localparam logic [3:0] P_D1   = 4'b1100;
  localparam logic [3:0] P_D2   = 4'b1000;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, lock = 1'b1;
  logic pll_rst_n, byp_off, oe, rdy;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pll_startup_seq #(.REF_HZ(64'd1_000_000), .RELEASE_US(10), .LOCK_US(60), .WAIT_LOCK(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .lock_i(lock),
    .pll_rst_n_o(pll_rst_n), .bypass_off_o(byp_off), .out_en_o(oe), .ready_o(rdy)
  );

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pll_rst_n, byp_off, oe, rdy};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: {rst_n,byp_off,oe,ready} actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  function automatic logic [3:0] bringup_pat(input int i);
    if (i < T1) return P_REL;
    if (i < T1 + T2) return P_LW;
    return P_RUN;
  endfunction

  function automatic string bringup_req(input int i);
    if (i < T1) return "R2";
    if (i < T1 + T2) return "R3";
    return "R4/R6";
  endfunction

  task automatic settle_idle();
    en = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", P_IDLE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", P_IDLE);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", P_IDLE);

    // Sweep: hold enable for d+1 sampled cycles, then drop it (R2, R3, R4, R7, R8)
    for (int d = 0; d <= T1 + T2 + 2; d++) begin
      settle_idle();
      en = 1'b1;
      for (int i = 0; i <= d; i++) begin
        @(negedge clk);
        check(bringup_req(i), bringup_pat(i));
      end
      en = 1'b0;
      if (d >= T1 + T2) begin
        @(negedge clk); check("R7", P_D1);
        @(negedge clk); check("R7", P_D2);
        @(negedge clk); check("R7", P_IDLE);
      end else if (d >= T1) begin
        @(negedge clk); check("R8", P_D2);
        @(negedge clk); check("R8", P_IDLE);
      end else begin
        @(negedge clk); check("R8", P_IDLE);
      end
    end

    // R5: lock held low past the wait
    settle_idle();
    lock = 1'b0;
    en = 1'b1;
    for (int i = 0; i < T1 + T2 + 8; i++) begin
      @(negedge clk);
      check("R5", (i < T1) ? P_REL : P_LW);
    end
    lock = 1'b1;
    @(negedge clk); check("R5", P_RUN);
    // R10: losing lock while running is ignored
    lock = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); check("R10", P_RUN);
    end
    lock = 1'b1;

    // R9: enable returns during shutdown
    en = 1'b0;
    @(negedge clk); check("R9", P_D1);
    en = 1'b1;
    @(negedge clk); check("R9", P_D2);
    @(negedge clk); check("R9", P_IDLE);
    @(negedge clk); check("R9", P_REL);
    for (int i = 1; i < T1 + T2 + 2; i++) begin
      @(negedge clk); check("R9", bringup_pat(i));
    end
    settle_idle();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule